// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Flash-Access Registers

This block is a serial test access port that follows the IEEE 1149.1 model. A four-wire port carries a clock, a mode-select line, serial data in and serial data out. A sixteen-state controller walks through the capture, shift and update phases. A 16-bit instruction register chooses which data register sits between the serial input and the serial output.

Three data registers serve standard test work:
- a parameterised boundary chain that observes and drives device pins;
- a fixed 32-bit identification word;
- a one-bit bypass stage.

Four more registers give the rest of the chip a path into its flash controller. They hold control, data, address and timing-scale values. Each has a parallel input that is sampled during capture, a parallel output, and a one-clock update pulse.

The pulse and the parallel output are what the flash logic consumes. The rest of the chip never sees the shift path.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `rstN` is low and right after it rises, the controller is in Test-Logic-Reset. `tdoEn`, `tdo`, every update pulse and every parallel output read 0. The instruction register holds 0x0000, the pin-driving test. One clock with `tms` low then enters Run-Test/Idle, where `bsDriveEn` reads 1.
- R2: Five rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. `bsDriveEn` is 0 there. The next rising edge reloads the instruction 0x0000, so the boundary chain is selected again.
- R3: On the Capture-IR edge the instruction shift register loads 0x0001. Its bits leave on `tdo` LSB first during Shift-IR.
- R4: Instruction 0x0004 selects the 32-bit identification register. Capture-DR loads the `ID_VALUE` parameter, which is shifted out LSB first.
- R5: Instruction 0xFFFF, and every 16-bit value outside the eight defined codes, selects a one-bit bypass stage. That stage captures 0, so the output stream is a 0 followed by `tdi` delayed by one clock.
- R6: Instructions 0x0000 (pin-driving test) and 0x0002 (sample/preload) both select the boundary chain. Capture-DR loads `bsIn` and Update-DR moves the shifted word to `bsOut`. `bsDriveEn` is 1 only while 0x0000 is the active instruction and the controller is outside Test-Logic-Reset.
- R7: Instructions 0x0082, 0x0083, 0x0084 and 0x0085 select the flash control, data, address and scale registers respectively. Capture-DR loads that register's parallel input. The rising edge in Update-DR copies the shifted word to its parallel output and raises only its update pulse for exactly one `tck` cycle. The other registers' outputs keep their values.
- R8: `tdo` and `tdoEn` change only on falling `tck` edges. `tdoEn` is 1 exactly while the controller is in Shift-IR or Shift-DR, and `tdo` reads 0 whenever `tdoEn` is 0.
- R9: A newly shifted instruction has no effect until the Update-IR edge. Through Shift-IR and Exit1-IR, the previous instruction still controls `bsDriveEn` and register selection.
- R10: Data registers shift toward the LSB, with `tdi` entering at the MSB. After N shift edges, an N-bit register holds the N `tdi` bits with the first bit at the LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdoEn | output | 1 | High while `tdo` carries valid shift data |
| bsIn | input | BS_LEN | Pin values observed by the boundary chain |
| bsOut | output | BS_LEN | Boundary update latches, the values to drive on pins |
| bsDriveEn | output | 1 | Boundary latches own the pins |
| flCtrlIn | input | FL_CTRL_W | Parallel capture value, flash control |
| flCtrlOut | output | FL_CTRL_W | Parallel output, flash control |
| flCtrlUpd | output | 1 | One-cycle update pulse, flash control |
| flDataIn | input | FL_DATA_W | Parallel capture value, flash data |
| flDataOut | output | FL_DATA_W | Parallel output, flash data |
| flDataUpd | output | 1 | One-cycle update pulse, flash data |
| flAddrIn | input | FL_ADDR_W | Parallel capture value, flash address |
| flAddrOut | output | FL_ADDR_W | Parallel output, flash address |
| flAddrUpd | output | 1 | One-cycle update pulse, flash address |
| flScaleIn | input | FL_SCALE_W | Parallel capture value, flash timing scale |
| flScaleOut | output | FL_SCALE_W | Parallel output, flash timing scale |
| flScaleUpd | output | 1 | One-cycle update pulse, flash timing scale |

## Verification
A wrong controller state shows up on `tdoEn` at the next falling edge. A wrong state after five high `tms` edges shows up on `bsDriveEn` at the following rising edge. A wrongly decoded instruction becomes visible on the first shifted bit. The first bit differs by register: 0 for bypass, the identification LSB for the ID register, and a parallel-input bit for boundary or flash registers. A word of the wrong length surfaces as a shifted-out pattern that is offset from the expected one. A stale or misrouted update appears one clock after Update-DR, either as a pulse on the wrong flash line or as an unchanged parallel output.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tapState_e;

  // strobes from the controller to the datapath, valid for the coming rising edge
  typedef struct packed {
    logic tlReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
  } tapCtrl_t;

  localparam int IR_W = 16;

  localparam logic [IR_W-1:0] OP_PIN_TEST = 16'h0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 16'h0002;
  localparam logic [IR_W-1:0] OP_IDENT    = 16'h0004;
  localparam logic [IR_W-1:0] OP_BYPASS   = 16'hFFFF;
  localparam logic [IR_W-1:0] OP_FL_CTRL  = 16'h0082;
  localparam logic [IR_W-1:0] OP_FL_DATA  = 16'h0083;
  localparam logic [IR_W-1:0] OP_FL_ADDR  = 16'h0084;
  localparam logic [IR_W-1:0] OP_FL_SCALE = 16'h0085;

  typedef enum logic [2:0] {
    DR_BOUND, DR_IDENT, DR_BYPASS, DR_FL_CTRL, DR_FL_DATA, DR_FL_ADDR, DR_FL_SCALE
  } drSel_e;

  function automatic drSel_e decodeOp(input logic [IR_W-1:0] op);
    drSel_e s;
    case (op)
      OP_PIN_TEST, OP_SAMPLE: s = DR_BOUND;
      OP_IDENT:               s = DR_IDENT;
      OP_FL_CTRL:             s = DR_FL_CTRL;
      OP_FL_DATA:             s = DR_FL_DATA;
      OP_FL_ADDR:             s = DR_FL_ADDR;
      OP_FL_SCALE:            s = DR_FL_SCALE;
      default:                s = DR_BYPASS;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic     tck,
  input  logic     rstN,
  input  logic     tms,
  output tapCtrl_t ctrl
);

  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      TS_RESET:    nextState = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     nextState = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   nextState = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   nextState = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: nextState = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: nextState = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: nextState = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: nextState = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   nextState = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   nextState = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   nextState = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: nextState = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: nextState = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: nextState = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: nextState = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   nextState = tms ? TS_SEL_DR   : TS_IDLE;
      default:     nextState = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= TS_RESET;
    else       state <= nextState;
  end

  always_comb begin
    ctrl.tlReset = (state == TS_RESET);
    ctrl.capIr   = (state == TS_CAP_IR);
    ctrl.shIr    = (state == TS_SHIFT_IR);
    ctrl.updIr   = (state == TS_UPD_IR);
    ctrl.capDr   = (state == TS_CAP_DR);
    ctrl.shDr    = (state == TS_SHIFT_DR);
    ctrl.updDr   = (state == TS_UPD_DR);
  end

endmodule

// File: rtl/scan_par_reg.sv
module scan_par_reg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rstN,
  input  logic         sel,
  input  logic         cap,
  input  logic         sh,
  input  logic         upd,
  input  logic         tdi,
  input  logic [W-1:0] parIn,
  output logic         sout,
  output logic [W-1:0] parOut,
  output logic         updPulse
);

  logic [W-1:0] shiftQ;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      parOut   <= '0;
      updPulse <= 1'b0;
    end else begin
      updPulse <= 1'b0;
      if (sel && cap)     shiftQ <= parIn;
      else if (sel && sh) shiftQ <= {tdi, shiftQ[W-1:1]};
      if (sel && upd) begin
        parOut   <= shiftQ;
        updPulse <= 1'b1;
      end
    end
  end

  assign sout = shiftQ[0];

endmodule

// File: rtl/scan_tap_datapath.sv
module scan_tap_datapath
  import scan_tap_pkg::*;
#(
  parameter int          BS_LEN     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h1A4C_5027,
  parameter int          FL_CTRL_W  = 8,
  parameter int          FL_DATA_W  = 8,
  parameter int          FL_ADDR_W  = 17,
  parameter int          FL_SCALE_W = 8
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  tdi,
  input  tapCtrl_t              ctrl,
  output logic                  tdo,
  output logic                  tdoEn,
  input  logic [BS_LEN-1:0]     bsIn,
  output logic [BS_LEN-1:0]     bsOut,
  output logic                  bsDriveEn,
  input  logic [FL_CTRL_W-1:0]  flCtrlIn,
  output logic [FL_CTRL_W-1:0]  flCtrlOut,
  output logic                  flCtrlUpd,
  input  logic [FL_DATA_W-1:0]  flDataIn,
  output logic [FL_DATA_W-1:0]  flDataOut,
  output logic                  flDataUpd,
  input  logic [FL_ADDR_W-1:0]  flAddrIn,
  output logic [FL_ADDR_W-1:0]  flAddrOut,
  output logic                  flAddrUpd,
  input  logic [FL_SCALE_W-1:0] flScaleIn,
  output logic [FL_SCALE_W-1:0] flScaleOut,
  output logic                  flScaleUpd
);

  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0]   irShift, irReg;
  logic [BS_LEN-1:0] bsShift;
  logic [ID_W-1:0]   idShift;
  logic              bypQ;
  drSel_e            sel;
  logic              serialBit, shiftNow;
  logic              ctrlOut, dataOut, addrOut, scaleOut;

  // instruction path
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           irShift <= '0;
    else if (ctrl.capIr) irShift <= IR_CAPTURE;
    else if (ctrl.shIr)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)             irReg <= OP_PIN_TEST;
    else if (ctrl.tlReset) irReg <= OP_PIN_TEST;
    else if (ctrl.updIr)   irReg <= irShift;
  end

  assign sel       = decodeOp(irReg);
  assign bsDriveEn = (irReg == OP_PIN_TEST) && !ctrl.tlReset;

  // boundary chain
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bsShift <= '0;
      bsOut   <= '0;
    end else if (sel == DR_BOUND) begin
      if (ctrl.capDr)     bsShift <= bsIn;
      else if (ctrl.shDr) bsShift <= {tdi, bsShift[BS_LEN-1:1]};
      if (ctrl.updDr)     bsOut   <= bsShift;
    end
  end

  // identification word
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) idShift <= '0;
    else if (sel == DR_IDENT) begin
      if (ctrl.capDr)     idShift <= ID_VALUE;
      else if (ctrl.shDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // bypass stage
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) bypQ <= 1'b0;
    else if (sel == DR_BYPASS) begin
      if (ctrl.capDr)     bypQ <= 1'b0;
      else if (ctrl.shDr) bypQ <= tdi;
    end
  end

  // flash-access registers
  scan_par_reg #(.W(FL_CTRL_W)) flCtrl_i (
    .tck(tck), .rstN(rstN), .sel(sel == DR_FL_CTRL),
    .cap(ctrl.capDr), .sh(ctrl.shDr), .upd(ctrl.updDr), .tdi(tdi),
    .parIn(flCtrlIn), .sout(ctrlOut), .parOut(flCtrlOut), .updPulse(flCtrlUpd));

  scan_par_reg #(.W(FL_DATA_W)) flData_i (
    .tck(tck), .rstN(rstN), .sel(sel == DR_FL_DATA),
    .cap(ctrl.capDr), .sh(ctrl.shDr), .upd(ctrl.updDr), .tdi(tdi),
    .parIn(flDataIn), .sout(dataOut), .parOut(flDataOut), .updPulse(flDataUpd));

  scan_par_reg #(.W(FL_ADDR_W)) flAddr_i (
    .tck(tck), .rstN(rstN), .sel(sel == DR_FL_ADDR),
    .cap(ctrl.capDr), .sh(ctrl.shDr), .upd(ctrl.updDr), .tdi(tdi),
    .parIn(flAddrIn), .sout(addrOut), .parOut(flAddrOut), .updPulse(flAddrUpd));

  scan_par_reg #(.W(FL_SCALE_W)) flScale_i (
    .tck(tck), .rstN(rstN), .sel(sel == DR_FL_SCALE),
    .cap(ctrl.capDr), .sh(ctrl.shDr), .upd(ctrl.updDr), .tdi(tdi),
    .parIn(flScaleIn), .sout(scaleOut), .parOut(flScaleOut), .updPulse(flScaleUpd));

  // serial output select
  always_comb begin
    if (ctrl.shIr) serialBit = irShift[0];
    else begin
      case (sel)
        DR_BOUND:    serialBit = bsShift[0];
        DR_IDENT:    serialBit = idShift[0];
        DR_FL_CTRL:  serialBit = ctrlOut;
        DR_FL_DATA:  serialBit = dataOut;
        DR_FL_ADDR:  serialBit = addrOut;
        DR_FL_SCALE: serialBit = scaleOut;
        default:     serialBit = bypQ;
      endcase
    end
  end

  assign shiftNow = ctrl.shIr || ctrl.shDr;

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= shiftNow ? serialBit : 1'b0;
      tdoEn <= shiftNow;
    end
  end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int          BS_LEN     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h1A4C_5027,
  parameter int          FL_CTRL_W  = 8,
  parameter int          FL_DATA_W  = 8,
  parameter int          FL_ADDR_W  = 17,
  parameter int          FL_SCALE_W = 8
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  tms,
  input  logic                  tdi,
  output logic                  tdo,
  output logic                  tdoEn,
  input  logic [BS_LEN-1:0]     bsIn,
  output logic [BS_LEN-1:0]     bsOut,
  output logic                  bsDriveEn,
  input  logic [FL_CTRL_W-1:0]  flCtrlIn,
  output logic [FL_CTRL_W-1:0]  flCtrlOut,
  output logic                  flCtrlUpd,
  input  logic [FL_DATA_W-1:0]  flDataIn,
  output logic [FL_DATA_W-1:0]  flDataOut,
  output logic                  flDataUpd,
  input  logic [FL_ADDR_W-1:0]  flAddrIn,
  output logic [FL_ADDR_W-1:0]  flAddrOut,
  output logic                  flAddrUpd,
  input  logic [FL_SCALE_W-1:0] flScaleIn,
  output logic [FL_SCALE_W-1:0] flScaleOut,
  output logic                  flScaleUpd
);

  tapCtrl_t ctrlBus;

  scan_tap_fsm fsm_i (
    .tck(tck), .rstN(rstN), .tms(tms), .ctrl(ctrlBus));

  scan_tap_datapath #(
    .BS_LEN(BS_LEN), .ID_VALUE(ID_VALUE), .FL_CTRL_W(FL_CTRL_W),
    .FL_DATA_W(FL_DATA_W), .FL_ADDR_W(FL_ADDR_W), .FL_SCALE_W(FL_SCALE_W)
  ) dp_i (
    .tck(tck), .rstN(rstN), .tdi(tdi), .ctrl(ctrlBus),
    .tdo(tdo), .tdoEn(tdoEn),
    .bsIn(bsIn), .bsOut(bsOut), .bsDriveEn(bsDriveEn),
    .flCtrlIn(flCtrlIn), .flCtrlOut(flCtrlOut), .flCtrlUpd(flCtrlUpd),
    .flDataIn(flDataIn), .flDataOut(flDataOut), .flDataUpd(flDataUpd),
    .flAddrIn(flAddrIn), .flAddrOut(flAddrOut), .flAddrUpd(flAddrUpd),
    .flScaleIn(flScaleIn), .flScaleOut(flScaleOut), .flScaleUpd(flScaleUpd));

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic       tck,
  input logic       rstN,
  input logic       tms,
  input logic       tdo,
  input logic       tdoEn,
  input logic       bsDriveEn,
  input tapCtrl_t   ctrl,
  input logic [3:0] updVec
);

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!rstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> ctrl.tlReset);

  // R8
  tdo_window_chk: assert property (@(posedge tck) disable iff (!rstN)
    tdoEn == (ctrl.shIr || ctrl.shDr));

  // R8
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rstN)
    !tdoEn |-> !tdo);

  // R9
  drive_rise_chk: assert property (@(posedge tck) disable iff (!rstN)
    $rose(bsDriveEn) |-> ($past(ctrl.updIr) || $past(ctrl.tlReset)));

  // R7
  strobe_pulse_chk: assert property (@(posedge tck) disable iff (!rstN)
    (|updVec) |=> !(|updVec));

  // R7
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0(updVec));

  // R7
  strobe_cause_chk: assert property (@(posedge tck) disable iff (!rstN)
    (|updVec) |-> $past(ctrl.updDr));

endmodule

bind scan_tap_ctrl scan_tap_chk chk_i (
  .tck(tck), .rstN(rstN), .tms(tms), .tdo(tdo), .tdoEn(tdoEn),
  .bsDriveEn(bsDriveEn), .ctrl(ctrlBus),
  .updVec({flCtrlUpd, flDataUpd, flAddrUpd, flScaleUpd}));

// File: tb/scan_tap_ctrl_tb_top.sv
module scan_tap_ctrl_tb_top;

  localparam int          BS_LEN = 8;
  localparam logic [31:0] IDV    = 32'h1A4C_5027;

  logic tck = 1'b0, rstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, bsDriveEn;
  logic [BS_LEN-1:0] bsIn = '0, bsOut;
  logic [7:0]  flCtrlIn = '0, flCtrlOut, flDataIn = '0, flDataOut, flScaleIn = '0, flScaleOut;
  logic [16:0] flAddrIn = '0, flAddrOut;
  logic flCtrlUpd, flDataUpd, flAddrUpd, flScaleUpd;

  int checkCnt = 0, failCnt = 0;
  logic expQ[$];
  bit monOff = 0;
  bit edgeBad = 0;
  bit done = 0;

  always #5 tck = ~tck;

  scan_tap_ctrl dut_i (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsIn(bsIn), .bsOut(bsOut), .bsDriveEn(bsDriveEn),
    .flCtrlIn(flCtrlIn), .flCtrlOut(flCtrlOut), .flCtrlUpd(flCtrlUpd),
    .flDataIn(flDataIn), .flDataOut(flDataOut), .flDataUpd(flDataUpd),
    .flAddrIn(flAddrIn), .flAddrOut(flAddrOut), .flAddrUpd(flAddrUpd),
    .flScaleIn(flScaleIn), .flScaleOut(flScaleOut), .flScaleUpd(flScaleUpd));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every valid serial bit against the scoreboard queue (R3 R4 R5 R6 R7 R10)
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (tdoEn && !monOff) begin
        if (expQ.size() == 0) check(1'b0, "R8 unexpected tdo bit", {63'b0, tdo}, 64'h0);
        else begin
          logic e;
          e = expQ.pop_front();
          check(tdo === e, "R10 serial bit", {63'b0, tdo}, {63'b0, e});
        end
      end
    end
  end

  // R8: tdo/tdoEn never move at a rising edge
  always @(posedge tck) begin
    logic a, b;
    a = tdo; b = tdoEn;
    #1;
    if (rstN && (tdo !== a || tdoEn !== b)) edgeBad = 1;
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
  endtask

  task automatic enterDr();
    step(1, 0); step(0, 0); step(0, 0);
  endtask

  task automatic enterIr();
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
  endtask

  task automatic shiftBits(input int n, input logic [63:0] din, input logic [63:0] exp);
    for (int i = 0; i < n; i++) expQ.push_back(exp[i]);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
  endtask

  task automatic finishUpd();
    step(1, 0); step(0, 0);
  endtask

  task automatic loadIr(input logic [15:0] code);
    enterIr();
    shiftBits(16, {48'b0, code}, 64'h1);
    finishUpd();
  endtask

  function automatic logic [63:0] outVal(input int idx);
    case (idx)
      0: return {56'b0, flCtrlOut};
      1: return {56'b0, flDataOut};
      2: return {47'b0, flAddrOut};
      default: return {56'b0, flScaleOut};
    endcase
  endfunction

  task automatic flashRun(input logic [15:0] op, input int w, input int idx,
                          input logic [63:0] din, input logic [63:0] parExp);
    logic [3:0] v;
    loadIr(op);
    enterDr();
    shiftBits(w, din, parExp);
    finishUpd();
    @(posedge tck); #2;
    v = {flCtrlUpd, flDataUpd, flAddrUpd, flScaleUpd};
    check(v == (4'b1000 >> idx), "R7 update pulse", {60'b0, v}, {60'b0, 4'b1000 >> idx});
    check(outVal(idx) == din, "R7 parallel out", outVal(idx), din);
    @(posedge tck); #2;
    v = {flCtrlUpd, flDataUpd, flAddrUpd, flScaleUpd};
    check(v == 4'b0, "R7 pulse one cycle", {60'b0, v}, 64'h0);
  endtask

  initial begin
    repeat (40000) @(posedge tck);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #2;
    // R1 reset state
    check(tdoEn == 0 && tdo == 0, "R1 tdo idle", {62'b0, tdoEn, tdo}, 64'h0);
    check({flCtrlUpd, flDataUpd, flAddrUpd, flScaleUpd} == 0 && bsOut == 0 && flAddrOut == 0,
          "R1 outputs zero", {47'b0, flAddrOut}, 64'h0);
    check(bsDriveEn == 0, "R1 no drive in reset", {63'b0, bsDriveEn}, 64'h0);
    @(negedge tck); #1 rstN = 1;
    step(0, 0);
    @(posedge tck); #2;
    check(bsDriveEn == 1, "R1 pin test after reset", {63'b0, bsDriveEn}, 64'h1);

    // R9 + R3: shift sample/preload code, old instruction still active until update
    enterIr();
    shiftBits(16, 64'h0002, 64'h0001);
    @(posedge tck); #2;
    check(bsDriveEn == 1, "R9 old instr holds", {63'b0, bsDriveEn}, 64'h1);
    finishUpd();
    @(posedge tck); #2;
    check(bsDriveEn == 0, "R9 new instr at update", {63'b0, bsDriveEn}, 64'h0);

    // R6 sample/preload
    bsIn = 8'hA5;
    enterDr();
    shiftBits(BS_LEN, 64'h3C, 64'hA5);
    finishUpd();
    @(posedge tck); #2;
    check(bsOut == 8'h3C, "R6 preload latches", {56'b0, bsOut}, 64'h3C);
    check(bsDriveEn == 0, "R6 sample no drive", {63'b0, bsDriveEn}, 64'h0);

    // R6 pin test
    loadIr(16'h0000);
    @(posedge tck); #2;
    check(bsDriveEn == 1 && bsOut == 8'h3C, "R6 drive preset value", {55'b0, bsDriveEn, bsOut}, 64'h13C);
    bsIn = 8'h5E;
    enterDr();
    shiftBits(BS_LEN, 64'h81, 64'h5E);
    finishUpd();
    @(posedge tck); #2;
    check(bsOut == 8'h81, "R6 drive update", {56'b0, bsOut}, 64'h81);

    // R4 identification
    loadIr(16'h0004);
    enterDr();
    shiftBits(32, 64'hFFFF_0000, {32'b0, IDV});
    finishUpd();

    // R5 bypass, defined and undefined codes
    loadIr(16'hFFFF);
    enterDr();
    shiftBits(8, 64'hB1, 64'h62);
    finishUpd();
    loadIr(16'h1234);
    enterDr();
    shiftBits(8, 64'hC7, 64'h8E);
    finishUpd();
    loadIr(16'h0081);
    enterDr();
    shiftBits(8, 64'h5B, 64'hB6);
    finishUpd();

    // R7 flash registers
    flCtrlIn = 8'h5A; flDataIn = 8'h96; flAddrIn = 17'h12345; flScaleIn = 8'h71;
    flashRun(16'h0082, 8, 0, 64'hC3, 64'h5A);
    flashRun(16'h0083, 8, 1, 64'h3E, 64'h96);
    flashRun(16'h0084, 17, 2, 64'h0ABCD, 64'h12345);
    flashRun(16'h0085, 8, 3, 64'h0F, 64'h71);
    check(flCtrlOut == 8'hC3 && flDataOut == 8'h3E && flAddrOut == 17'h0ABCD && flScaleOut == 8'h0F,
          "R7 others unchanged", {31'b0, flCtrlOut, flDataOut, flAddrOut[15:0]}, {31'b0, 8'hC3, 8'h3E, 16'hABCD});
    check(bsOut == 8'h81, "R7 boundary untouched", {56'b0, bsOut}, 64'h81);

    // R2 five high tms from Shift-DR with identification selected
    loadIr(16'h0004);
    enterDr();
    monOff = 1;
    step(0, 1); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    @(posedge tck); #2;
    check(bsDriveEn == 0, "R2 test-logic-reset no drive", {63'b0, bsDriveEn}, 64'h0);
    @(negedge tck); #2;
    check(tdoEn == 0, "R2 tdo off in reset", {63'b0, tdoEn}, 64'h0);
    monOff = 0;
    step(0, 0);
    @(posedge tck); #2;
    check(bsDriveEn == 1, "R2 instr reloaded", {63'b0, bsDriveEn}, 64'h1);
    bsIn = 8'h6D;
    enterDr();
    shiftBits(BS_LEN, 64'h00, 64'h6D);
    finishUpd();

    // R2 from Pause-IR
    loadIr(16'hFFFF);
    step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    @(posedge tck); #2;
    check(bsDriveEn == 0, "R2 reset from pause", {63'b0, bsDriveEn}, 64'h0);
    step(0, 0);
    @(posedge tck); #2;
    check(bsDriveEn == 1, "R2 reload from pause", {63'b0, bsDriveEn}, 64'h1);

    repeat (3) @(posedge tck);
    check(expQ.size() == 0, "R10 all bits seen", expQ.size(), 64'h0);
    check(!edgeBad, "R8 no change at rising edge", {63'b0, edgeBad}, 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule